// File: doc/BRIEF.md
# CSR Instruction Bus Sequencer

This block runs the six RISC-V CSR instructions for an execution core that keeps no control and status registers of its own. The CSR file sits outside the core on a simple synchronous bus. The core hands the block a decoded 32-bit instruction, the value of rs1 and a one-cycle start strobe. The block then drives the CSR address, the write data and the read and write enables. It takes in a same-cycle valid flag and the read data, and it returns the old CSR value for rd with a one-cycle done pulse. When the access is illegal, it pulses a trap output instead.

The read and write enables follow the instruction's own fields. The read enable needs a nonzero rd, and the write enable needs a nonzero rs1 index (or a nonzero immediate). A swap can read and write in one bus cycle. A set or a clear reads in one cycle, keeps the old value, and writes the modified value in the next cycle.

The controller has five states:
- `ST_IDLE` waits for start. An accepted start captures the operands and moves to `ST_ACCESS`.
- `ST_ACCESS` drives the address and samples the valid flag. From there it goes to `ST_TRAP` on an illegal access, to `ST_DONE` for a swap or when nothing needs writing, and otherwise to `ST_WRITE`.
- `ST_WRITE` performs the modify write and then moves to `ST_DONE`.
- `ST_DONE` and `ST_TRAP` each last one cycle and return to `ST_IDLE`.

Top module: `csr_seq`

## Requirements
- R1: Whenever the read enable or the write enable is high, the bus address equals bits 31:20 of the instruction accepted by the last start.
- R2: If the valid flag is low in the access cycle, trap_o pulses for exactly one cycle in the next cycle, no write enable is raised for that instruction, and no done pulse follows.
- R3: The write enable is raised only if instruction bits 19:15 (the rs1 index or the immediate) are nonzero.
- R4: The read enable is raised only if instruction bits 11:7 (the rd index) are nonzero, and only in the access cycle.
- R5: A swap (bits 14:12 = 001 or 101) makes one bus cycle with both enables as the fields allow, writes the mask, and gives done one cycle after the access cycle.
- R6: A set (010/110) or a clear (011/111) with a nonzero mask field reads in the access cycle with the write enable low. It then writes old OR mask (set) or old AND NOT mask (clear) in the next cycle with the read enable low. With a zero mask field no write cycle occurs.
- R7: For the immediate forms (bit 14 = 1), the mask is bits 19:15 zero-extended to 64 bits. Otherwise the mask is the rs1 value.
- R8: done_o is a one-cycle pulse given only when rd is nonzero and no trap occurred. While it is high, rd_data_o holds the CSR value read in the access cycle and rd_idx_o holds bits 11:7.
- R9: busy_o rises in the cycle after an accepted start and stays high until the block is back in idle. A start while busy is ignored, and the bus address stays stable.
- R10: Bits 14:12 equal to 000 or 100, or bits 6:0 not equal to 1110011, make a trap one cycle after the access cycle with no bus enable at all.
- R11: After reset the block is idle, with busy_o, done_o, trap_o and both bus enables low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe, accepted only when idle |
| insn_i | input | 32 | Decoded CSR instruction word |
| rs1_val_i | input | 64 | Value of register rs1 |
| bus_addr_o | output | 12 | CSR address on the bus |
| bus_wdata_o | output | 64 | Data to write into the addressed CSR |
| bus_we_o | output | 1 | Write enable |
| bus_oe_o | output | 1 | Read enable |
| bus_valid_i | input | 1 | Address maps to an existing CSR (same-cycle decode) |
| bus_rdata_i | input | 64 | Current value of the addressed CSR |
| rd_data_o | output | 64 | Old CSR value for write-back to rd |
| rd_idx_o | output | 5 | Destination register index |
| done_o | output | 1 | One-cycle write-back pulse |
| trap_o | output | 1 | One-cycle illegal-instruction pulse |
| busy_o | output | 1 | Sequencer is working on an instruction |

## Verification
The bound checker checks on every cycle the properties that follow from the fields of the accepted instruction:
- both enables are gated by their fields, the read enable by rd and the write enable by the rs1 field;
- the address matches bits 31:20 whenever a bus enable is high;
- no enable is raised against a low valid flag;
- done and trap are single-cycle pulses that never coincide;
- the address holds steady while the block is busy.

Only the bench scenarios can show the data results and the cycle ordering. These include the value written by a swap, a set or a clear against a CSR model, the split between the read cycle and the write cycle, the zero-extended immediate mask, the old value returned to rd, and that a start arriving mid-operation leaves the other CSR untouched.

// File: rtl/csr_seq_pkg.sv
`timescale 1ns/1ps
package csr_seq_pkg;

    localparam int CSR_ADDR_W = 12;
    localparam int REG_IDX_W  = 5;
    localparam int INSN_W     = 32;
    localparam logic [6:0] OPC_SYSTEM = 7'b1110011;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ACCESS,
        ST_WRITE,
        ST_DONE,
        ST_TRAP
    } seq_state_e;

    typedef enum logic [1:0] {
        OP_SWAP,
        OP_SET,
        OP_CLEAR,
        OP_NONE
    } csr_op_e;

    typedef struct packed {
        csr_op_e                 op;
        logic                    use_imm;
        logic [CSR_ADDR_W-1:0]   addr;
        logic [REG_IDX_W-1:0]    rd_idx;
        logic [REG_IDX_W-1:0]    src_idx;
        logic                    rd_nz;
        logic                    src_nz;
    } csr_dec_t;

endpackage

// File: rtl/csr_op_decode.sv
`timescale 1ns/1ps
module csr_op_decode
    import csr_seq_pkg::*;
(
    input  logic [INSN_W-1:0] insn_i,
    output csr_dec_t          dec_o
);

    always_comb begin
        dec_o.addr    = insn_i[31:20];
        dec_o.src_idx = insn_i[19:15];
        dec_o.rd_idx  = insn_i[11:7];
        dec_o.rd_nz   = |insn_i[11:7];
        dec_o.src_nz  = |insn_i[19:15];
        dec_o.use_imm = insn_i[14];
        case (insn_i[13:12])
            2'b01:   dec_o.op = OP_SWAP;
            2'b10:   dec_o.op = OP_SET;
            2'b11:   dec_o.op = OP_CLEAR;
            default: dec_o.op = OP_NONE;
        endcase
        if (insn_i[6:0] != OPC_SYSTEM) begin
            dec_o.op = OP_NONE;
        end
    end

endmodule

// File: rtl/csr_mask_alu.sv
`timescale 1ns/1ps
module csr_mask_alu
    import csr_seq_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  csr_op_e                 op_i,
    input  logic                    use_imm_i,
    input  logic [REG_IDX_W-1:0]    zimm_i,
    input  logic [XLEN-1:0]         rs1_val_i,
    input  logic [XLEN-1:0]         old_i,
    output logic [XLEN-1:0]         result_o
);

    localparam int ZPAD = XLEN - REG_IDX_W;

    logic [XLEN-1:0] mask;

    // Immediate forms widen the 5-bit field with zeros.
    always_comb begin
        if (use_imm_i) begin
            mask = {{ZPAD{1'b0}}, zimm_i};
        end else begin
            mask = rs1_val_i;
        end
    end

    always_comb begin
        unique case (op_i)
            OP_SET:   result_o = old_i | mask;
            OP_CLEAR: result_o = old_i & ~mask;
            OP_SWAP:  result_o = mask;
            default:  result_o = mask;
        endcase
    end

endmodule

// File: rtl/csr_seq_fsm.sv
`timescale 1ns/1ps
module csr_seq_fsm
    import csr_seq_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    start_i,
    input  csr_op_e op_i,
    input  logic    rd_nz_i,
    input  logic    src_nz_i,
    input  logic    bus_valid_i,
    output logic    capture_o,
    output logic    latch_old_o,
    output logic    we_o,
    output logic    oe_o,
    output logic    done_o,
    output logic    trap_o,
    output logic    busy_o
);

    seq_state_e state_q;
    seq_state_e state_d;
    logic       access_ok;

    assign access_ok = bus_valid_i && (op_i != OP_NONE);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    state_d = ST_ACCESS;
                end
            end
            ST_ACCESS: begin
                if (!access_ok) begin
                    state_d = ST_TRAP;
                end else if (op_i == OP_SWAP || !src_nz_i) begin
                    state_d = ST_DONE;
                end else begin
                    state_d = ST_WRITE;
                end
            end
            ST_WRITE: state_d = ST_DONE;
            ST_DONE:  state_d = ST_IDLE;
            ST_TRAP:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        capture_o   = 1'b0;
        latch_old_o = 1'b0;
        we_o        = 1'b0;
        oe_o        = 1'b0;
        done_o      = 1'b0;
        trap_o      = 1'b0;
        busy_o      = 1'b1;
        unique case (state_q)
            ST_IDLE: begin
                busy_o    = 1'b0;
                capture_o = start_i;
            end
            ST_ACCESS: begin
                latch_old_o = access_ok;
                oe_o        = access_ok && rd_nz_i;
                we_o        = access_ok && (op_i == OP_SWAP) && src_nz_i;
            end
            ST_WRITE: begin
                we_o = 1'b1;
            end
            ST_DONE: begin
                done_o = rd_nz_i;
            end
            ST_TRAP: begin
                trap_o = 1'b1;
            end
            default: begin
                busy_o = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/csr_seq.sv
`timescale 1ns/1ps
module csr_seq
    import csr_seq_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start_i,
    input  logic [INSN_W-1:0]     insn_i,
    input  logic [XLEN-1:0]       rs1_val_i,
    output logic [CSR_ADDR_W-1:0] bus_addr_o,
    output logic [XLEN-1:0]       bus_wdata_o,
    output logic                  bus_we_o,
    output logic                  bus_oe_o,
    input  logic                  bus_valid_i,
    input  logic [XLEN-1:0]       bus_rdata_i,
    output logic [XLEN-1:0]       rd_data_o,
    output logic [REG_IDX_W-1:0]  rd_idx_o,
    output logic                  done_o,
    output logic                  trap_o,
    output logic                  busy_o
);

    logic [INSN_W-1:0] insn_q;
    logic [XLEN-1:0]   rs1_q;
    logic [XLEN-1:0]   old_q;
    logic [XLEN-1:0]   alu_result;
    csr_dec_t          dec;
    logic              capture;
    logic              latch_old;
    logic              we;

    csr_op_decode u_decode (
        .insn_i (insn_q),
        .dec_o  (dec)
    );

    csr_mask_alu #(
        .XLEN (XLEN)
    ) u_alu (
        .op_i      (dec.op),
        .use_imm_i (dec.use_imm),
        .zimm_i    (dec.src_idx),
        .rs1_val_i (rs1_q),
        .old_i     (old_q),
        .result_o  (alu_result)
    );

    csr_seq_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .op_i        (dec.op),
        .rd_nz_i     (dec.rd_nz),
        .src_nz_i    (dec.src_nz),
        .bus_valid_i (bus_valid_i),
        .capture_o   (capture),
        .latch_old_o (latch_old),
        .we_o        (we),
        .oe_o        (bus_oe_o),
        .done_o      (done_o),
        .trap_o      (trap_o),
        .busy_o      (busy_o)
    );

    // Operand capture and old-value holding register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            insn_q <= '0;
            rs1_q  <= '0;
            old_q  <= '0;
        end else begin
            if (capture) begin
                insn_q <= insn_i;
                rs1_q  <= rs1_val_i;
            end
            if (latch_old) begin
                old_q <= bus_rdata_i;
            end
        end
    end

    assign bus_addr_o  = dec.addr;
    assign bus_we_o    = we;
    assign bus_wdata_o = we ? alu_result : '0;
    assign rd_data_o   = old_q;
    assign rd_idx_o    = dec.rd_idx;

endmodule

// File: rtl/csr_seq_chk.sv
`timescale 1ns/1ps
module csr_seq_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        start_i,
    input logic [31:0] insn_i,
    input logic [11:0] bus_addr_o,
    input logic        bus_we_o,
    input logic        bus_oe_o,
    input logic        bus_valid_i,
    input logic [4:0]  rd_idx_o,
    input logic        done_o,
    input logic        trap_o,
    input logic        busy_o
);

    logic [31:0] cap_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_q <= '0;
        end else if (start_i && !busy_o) begin
            cap_q <= insn_i;
        end
    end

    assert_addr_field_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we_o || bus_oe_o) |-> (bus_addr_o == cap_q[31:20]));

    assert_no_write_before_trap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        trap_o |-> !$past(bus_we_o));

    assert_trap_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        trap_o |=> !trap_o);

    assert_read_needs_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_oe_o |-> bus_valid_i);

    assert_we_field_R3: assert property (@(posedge clk) disable iff (!rst_n)
        bus_we_o |-> (cap_q[19:15] != 5'd0));

    assert_oe_field_R4: assert property (@(posedge clk) disable iff (!rst_n)
        bus_oe_o |-> (cap_q[11:7] != 5'd0));

    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_done_not_trap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!trap_o && rd_idx_o == cap_q[11:7] && cap_q[11:7] != 5'd0));

    assert_busy_after_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> busy_o);

    assert_addr_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> $stable(bus_addr_o));

endmodule

bind csr_seq csr_seq_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .insn_i      (insn_i),
    .bus_addr_o  (bus_addr_o),
    .bus_we_o    (bus_we_o),
    .bus_oe_o    (bus_oe_o),
    .bus_valid_i (bus_valid_i),
    .rd_idx_o    (rd_idx_o),
    .done_o      (done_o),
    .trap_o      (trap_o),
    .busy_o      (busy_o)
);

// File: tb/sim_csr_seq.sv
`timescale 1ns/1ps
module sim_csr_seq;

    localparam logic [2:0] F_RW  = 3'b001;
    localparam logic [2:0] F_RS  = 3'b010;
    localparam logic [2:0] F_RC  = 3'b011;
    localparam logic [2:0] F_RWI = 3'b101;
    localparam logic [2:0] F_RCI = 3'b111;
    localparam logic [11:0] CSR_A = 12'h340;
    localparam logic [11:0] CSR_B = 12'h305;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [31:0] insn_i = '0;
    logic [63:0] rs1_val_i = '0;
    logic [11:0] bus_addr_o;
    logic [63:0] bus_wdata_o;
    logic        bus_we_o;
    logic        bus_oe_o;
    logic        bus_valid_i;
    logic [63:0] bus_rdata_i;
    logic [63:0] rd_data_o;
    logic [4:0]  rd_idx_o;
    logic        done_o;
    logic        trap_o;
    logic        busy_o;

    logic [63:0] csr_a;
    logic [63:0] csr_b;

    int n_chk = 0;
    int n_err = 0;

    int ob_we, ob_oe, ob_both, ob_first_we, ob_first_oe, ob_done, ob_trap, ob_addr_bad;
    logic [63:0] ob_rd_data;
    logic [4:0]  ob_rd_idx;

    always #2.5 clk = ~clk;

    csr_seq u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .insn_i(insn_i),
        .rs1_val_i(rs1_val_i), .bus_addr_o(bus_addr_o), .bus_wdata_o(bus_wdata_o),
        .bus_we_o(bus_we_o), .bus_oe_o(bus_oe_o), .bus_valid_i(bus_valid_i),
        .bus_rdata_i(bus_rdata_i), .rd_data_o(rd_data_o), .rd_idx_o(rd_idx_o),
        .done_o(done_o), .trap_o(trap_o), .busy_o(busy_o)
    );

    // CSR file model: two registers, same-cycle valid decode
    always_comb begin
        bus_valid_i = (bus_addr_o == CSR_A) || (bus_addr_o == CSR_B);
        if (bus_addr_o == CSR_A)      bus_rdata_i = csr_a;
        else if (bus_addr_o == CSR_B) bus_rdata_i = csr_b;
        else                          bus_rdata_i = '0;
    end

    always @(posedge clk) begin
        if (bus_we_o) begin
            if (bus_addr_o == CSR_A)      csr_a <= bus_wdata_o;
            else if (bus_addr_o == CSR_B) csr_b <= bus_wdata_o;
        end
    end

    function automatic logic [31:0] enc(input logic [11:0] csr, input logic [4:0] src,
                                        input logic [2:0] f3, input logic [4:0] rd);
        return {csr, src, f3, rd, 7'b1110011};
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    endtask

    // Issue one instruction and watch six cycles starting with the access cycle
    task automatic run_op(input logic [31:0] insn, input logic [63:0] rs1v);
        ob_we = 0; ob_oe = 0; ob_both = 0; ob_first_we = -1; ob_first_oe = -1;
        ob_done = -1; ob_trap = -1; ob_addr_bad = 0; ob_rd_data = '0; ob_rd_idx = '0;
        @(negedge clk);
        insn_i = insn; rs1_val_i = rs1v; start_i = 1'b1;
        @(posedge clk); #1;
        start_i = 1'b0;
        for (int j = 0; j < 6; j++) begin
            if ((bus_we_o || bus_oe_o) && bus_addr_o != insn[31:20]) ob_addr_bad++;
            if (bus_we_o) begin
                ob_we++;
                if (ob_first_we < 0) ob_first_we = j;
                if (bus_oe_o) ob_both++;
            end
            if (bus_oe_o) begin
                ob_oe++;
                if (ob_first_oe < 0) ob_first_oe = j;
            end
            if (done_o) begin
                ob_done = j; ob_rd_data = rd_data_o; ob_rd_idx = rd_idx_o;
            end
            if (trap_o) ob_trap = j;
            @(posedge clk); #1;
        end
    endtask

    task automatic t_reset();
        chk("R11 busy after reset", 64'(busy_o), 0);
        chk("R11 we after reset", 64'(bus_we_o), 0);
        chk("R11 oe after reset", 64'(bus_oe_o), 0);
        chk("R11 done after reset", 64'(done_o), 0);
        chk("R11 trap after reset", 64'(trap_o), 0);
    endtask

    task automatic t_swap();
        csr_a = 64'h1111_2222_3333_4444;
        run_op(enc(CSR_A, 5'd1, F_RW, 5'd5), 64'hA5A5_0000_FFFF_0001);
        chk("R5 swap single cycle both enables", 64'(ob_both), 1);
        chk("R5 swap one write", 64'(ob_we), 1);
        chk("R5 swap done timing", 64'(ob_done), 1);
        chk("R8 swap old value", ob_rd_data, 64'h1111_2222_3333_4444);
        chk("R8 swap rd index", 64'(ob_rd_idx), 5);
        chk("R5 swap written value", csr_a, 64'hA5A5_0000_FFFF_0001);
        chk("R1 swap address", 64'(ob_addr_bad), 0);
    endtask

    task automatic t_swap_imm();
        csr_b = 64'hFFFF_FFFF_FFFF_FFFF;
        run_op(enc(CSR_B, 5'h1b, F_RWI, 5'd7), 64'hDEAD_BEEF_DEAD_BEEF);
        chk("R7 swap immediate zero-extended", csr_b, 64'h1b);
        chk("R8 swap immediate old value", ob_rd_data, 64'hFFFF_FFFF_FFFF_FFFF);
        chk("R1 swap immediate address", 64'(ob_addr_bad), 0);
    endtask

    task automatic t_swap_rd0();
        csr_a = 64'h55;
        run_op(enc(CSR_A, 5'd2, F_RW, 5'd0), 64'h99);
        chk("R4 no read when rd is x0", 64'(ob_oe), 0);
        chk("R8 no done when rd is x0", 64'(ob_done), -1);
        chk("R5 write without read", csr_a, 64'h99);
    endtask

    task automatic t_set();
        csr_a = 64'hF0;
        run_op(enc(CSR_A, 5'd4, F_RS, 5'd6), 64'h0F0F);
        chk("R6 set read cycle first", 64'(ob_first_oe), 0);
        chk("R6 set write in second cycle", 64'(ob_first_we), 1);
        chk("R6 set read and write apart", 64'(ob_both), 0);
        chk("R6 set result", csr_a, 64'h0FFF);
        chk("R8 set old value", ob_rd_data, 64'hF0);
        chk("R8 set done timing", 64'(ob_done), 2);
    endtask

    task automatic t_clear_imm();
        csr_b = 64'hFF;
        run_op(enc(CSR_B, 5'h05, F_RCI, 5'd9), 64'hFFFF_FFFF_FFFF_FFFF);
        chk("R7 clear immediate result", csr_b, 64'hFA);
        chk("R6 clear immediate one write", 64'(ob_we), 1);
        chk("R8 clear immediate rd index", 64'(ob_rd_idx), 9);
    endtask

    task automatic t_set_zero_mask();
        csr_a = 64'h1234;
        run_op(enc(CSR_A, 5'd0, F_RS, 5'd3), 64'hFFFF);
        chk("R3 no write with zero rs1 field", 64'(ob_we), 0);
        chk("R6 no write cycle, early done", 64'(ob_done), 1);
        chk("R8 read-only old value", ob_rd_data, 64'h1234);
        chk("R3 CSR untouched", csr_a, 64'h1234);
    endtask

    task automatic t_clear_rd0();
        csr_a = 64'hFF00;
        run_op(enc(CSR_A, 5'd8, F_RC, 5'd0), 64'h0F00);
        chk("R4 clear rd x0 no read enable", 64'(ob_oe), 0);
        chk("R6 clear rd x0 result", csr_a, 64'hF000);
        chk("R8 clear rd x0 no done", 64'(ob_done), -1);
    endtask

    task automatic t_bad_addr();
        csr_a = 64'h77; csr_b = 64'h88;
        run_op(enc(12'h7C0, 5'd1, F_RW, 5'd5), 64'h1);
        chk("R2 trap one cycle after access", 64'(ob_trap), 1);
        chk("R2 no write on trap", 64'(ob_we), 0);
        chk("R2 no done on trap", 64'(ob_done), -1);
        chk("R2 CSR A untouched", csr_a, 64'h77);
        chk("R2 CSR B untouched", csr_b, 64'h88);
    endtask

    task automatic t_bad_funct3();
        csr_a = 64'h42;
        run_op(enc(CSR_A, 5'd1, 3'b100, 5'd5), 64'hFF);
        chk("R10 trap on funct3 100", 64'(ob_trap), 1);
        chk("R10 no read enable", 64'(ob_oe), 0);
        chk("R10 no write enable", 64'(ob_we), 0);
        chk("R10 CSR untouched", csr_a, 64'h42);
        run_op(enc(CSR_A, 5'd1, 3'b000, 5'd5), 64'hFF);
        chk("R10 trap on funct3 000", 64'(ob_trap), 1);
    endtask

    task automatic t_busy_ignore();
        csr_a = 64'h10; csr_b = 64'h77;
        @(negedge clk);
        insn_i = enc(CSR_A, 5'd4, F_RS, 5'd6); rs1_val_i = 64'h3; start_i = 1'b1;
        @(posedge clk); #1;
        chk("R9 busy after start", 64'(busy_o), 1);
        insn_i = enc(CSR_B, 5'd3, F_RW, 5'd2); rs1_val_i = 64'hDEAD;
        @(posedge clk); #1;
        chk("R9 address held while busy", 64'(bus_addr_o), 64'(CSR_A));
        @(posedge clk); #1;
        chk("R9 first instruction completes", 64'(done_o), 1);
        chk("R9 first instruction old value", rd_data_o, 64'h10);
        start_i = 1'b0;
        repeat (3) begin @(posedge clk); #1; end
        chk("R9 idle again", 64'(busy_o), 0);
        chk("R9 ignored start left CSR B", csr_b, 64'h77);
        chk("R9 first instruction result", csr_a, 64'h13);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual=expired expected=finished");
        finish_run();
    end

    initial begin
        csr_a = '0; csr_b = '0;
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(posedge clk);
        #1;
        t_reset();
        t_swap();
        t_swap_imm();
        t_swap_rd0();
        t_set();
        t_clear_imm();
        t_set_zero_mask();
        t_clear_rd0();
        t_bad_addr();
        t_bad_funct3();
        t_busy_ignore();
        finish_run();
    end

endmodule